// File: doc/BRIEF.md
# Indexed-Opcode SPI Flash Cycle Engine

This block runs one serial flash transaction per start command. Software fills a menu of eight command opcodes, each tagged with a two-bit kind, and an optional prefix opcode. It also sets a 24-bit flash address and up to 64 bytes of data. A start is a single write to the control word. That word selects a menu entry by index, says whether a data phase follows, gives the byte count, picks the serial clock rate and can request a prefix cycle. The engine then drives a single-lane SPI mode 0 bus. It sends the opcode, then three address bytes if the entry's kind carries an address, then data bytes out of or into the buffer.

When a prefix is requested, the prefix opcode goes out first in its own chip-select frame. The chip select then stays high for at least two serial clock periods, and the main frame follows under the same start. Completion and error are sticky status flags that are cleared by writing 1. A lock flag freezes the menu, the kinds and the prefix until reset.

The register interface has 32-bit words, 5-bit word addresses, single-cycle writes and combinational reads:

| Word address | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | address (low 24 bits) |
| 3 | prefix opcode (low 8 bits) |
| 4 | kinds (16 bits) |
| 5 | menu entries 0 to 3 |
| 6 | menu entries 4 to 7 |
| 16 to 31 | data buffer |

In each packed word, the lowest-numbered entry or byte sits in bits 7:0.

Top module: `fcyc_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low and the status word reads 0.
- R2: Writing control with bit 0 set, while idle, starts a cycle. Control bits 6:4 pick the menu entry whose opcode is sent as the first byte of the frame. All bytes go MSB first in SPI mode 0: the clock idles low, MOSI changes only after a falling edge, and MISO is sampled on the rising edge.
- R3: Kind codes are 0 read without address, 1 write without address, 2 read with address and 3 write with address. They are packed two bits per entry in word 4, with entry 0 in bits 1:0. Kinds 2 and 3 send address bits 23:16, 15:8 and 7:0 after the opcode. Kinds 0 and 1 send no address.
- R4: Control bit 2 enables a data phase of (bits 13:8) + 1 bytes, from 1 to 64. For a write kind, the buffer bytes are sent starting at byte 0.
- R5: For a read kind with a data phase, the engine sends 0x00 on MOSI and stores each received byte into the buffer in arrival order, starting at byte 0.
- R6: With control bit 1 set, the prefix opcode (word 3) is sent as its own frame. Chip select then stays high for at least two serial clock periods before the main frame begins.
- R7: Control bit 3 selects the fast serial clock, with HALF_FAST system cycles per half period. When it is clear, the clock uses HALF_SLOW system cycles per half period.
- R8: Status bit 0 is high while a cycle runs. Status bit 1 is set when a cycle finishes, stays set, and is cleared by writing status with bit 1 set.
- R9: A start requested while a cycle runs sets status bit 2 and sends nothing extra. The running cycle is not disturbed. Writing status with bit 2 set clears the flag.
- R10: Writing status with bit 3 set raises the lock, and status bit 3 reads it. Once locked, writes to words 3, 4, 5 and 6 have no effect until reset.
- R11: The serial clock is low whenever chip select is high, and chip select is low only while status bit 0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A behavioural flash model on the bench records every frame and returns a known byte for each frame position. Against this model, the bench checks the following:

- **Address byte order and omission.** Swapped address bytes, or address bytes sent for a no-address kind, show up as wrong frame contents.
- **Full 64-byte data phase.** A count field off by one loses or adds a byte at the buffer boundary.
- **Prefix frame and gap.** A merged prefix frame, or a too-short chip-select gap, shows up as a missing frame or a gap count below the bound.
- **Start while busy.** A design that honoured the second start would emit an extra frame. One that dropped the error flag would read back a clean status.
- **Lock.** After the lock is raised, later menu writes must not reach the opcode that is actually sent.

// File: rtl/fcyc_pkg.sv
package fcyc_pkg;

  localparam int MENU_N    = 8;
  localparam int IDXW      = $clog2(MENU_N);
  localparam int BUF_BYTES = 64;
  localparam int CNTW      = $clog2(BUF_BYTES);
  localparam int RAW       = 5;

  localparam logic [RAW-1:0] A_CTRL = 5'd0;
  localparam logic [RAW-1:0] A_STAT = 5'd1;
  localparam logic [RAW-1:0] A_ADDR = 5'd2;
  localparam logic [RAW-1:0] A_PFX  = 5'd3;
  localparam logic [RAW-1:0] A_KIND = 5'd4;
  localparam logic [RAW-1:0] A_MLO  = 5'd5;
  localparam logic [RAW-1:0] A_MHI  = 5'd6;

  typedef enum logic [1:0] {
    K_RD  = 2'd0,
    K_WR  = 2'd1,
    K_RDA = 2'd2,
    K_WRA = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PFX, S_GAP, S_OPC, S_ADR, S_DAT, S_FIN
  } seq_st_t;

  typedef struct packed {
    logic            fast;
    logic [CNTW-1:0] cnt;
    logic [IDXW-1:0] idx;
    logic            dat_en;
    logic            atomic;
  } ctrl_t;

  function automatic logic kind_has_addr(op_kind_t k);
    return k[1];
  endfunction

  function automatic logic kind_is_write(op_kind_t k);
    return k[0];
  endfunction

  function automatic logic [7:0] addr_byte(logic [23:0] a, logic [1:0] i);
    case (i)
      2'd0:    return a[23:16];
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  function automatic ctrl_t ctrl_decode(logic [31:0] w);
    ctrl_t c;
    c.atomic = w[1];
    c.dat_en = w[2];
    c.fast   = w[3];
    c.idx    = w[6:4];
    c.cnt    = w[13:8];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_encode(ctrl_t c);
    return {18'd0, c.cnt, 1'b0, c.idx, c.fast, c.dat_en, c.atomic, 1'b0};
  endfunction

endpackage

// File: rtl/fcyc_shifter.sv
module fcyc_shifter #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      tx,
  input  logic [DIVW-1:0] half,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            done,
  output logic [7:0]      rx
);

  logic            active;
  logic [7:0]      sh;
  logic [2:0]      bitn;
  logic [DIVW-1:0] cnt;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck    <= 1'b0;
      sh     <= '0;
      rx     <= '0;
      bitn   <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sck    <= 1'b0;
        sh     <= tx;
        bitn   <= '0;
        cnt    <= half - 1'b1;
      end else if (active) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= half - 1'b1;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              sh   <= {sh[6:0], 1'b0};
              bitn <= bitn + 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/fcyc_seq.sv
module fcyc_seq
  import fcyc_pkg::*;
#(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  ctrl_t           cfg,
  input  logic [7:0]      opcode,
  input  op_kind_t        kind,
  input  logic [7:0]      prefix,
  input  logic [23:0]     addr,
  input  logic [DIVW-1:0] half,
  input  logic            sh_done,
  input  logic [7:0]      sh_rx,
  input  logic [7:0]      buf_rd,
  output logic            sh_start,
  output logic [7:0]      sh_tx,
  output logic            cs_n,
  output logic            busy,
  output logic            fin,
  output logic [CNTW-1:0] buf_idx,
  output logic            buf_we,
  output logic [7:0]      buf_wd
);

  seq_st_t         st;
  logic            launched;
  logic [CNTW-1:0] bidx;
  logic [DIVW+1:0] gap;
  ctrl_t           c_q;
  op_kind_t        k_q;
  logic [7:0]      op_q, pf_q;
  logic [23:0]     ad_q;
  logic            byte_st;
  seq_st_t         after_opc, after_adr;

  assign byte_st  = (st == S_PFX) || (st == S_OPC) || (st == S_ADR) || (st == S_DAT);
  assign sh_start = byte_st && !launched;
  assign cs_n     = !byte_st;
  assign busy     = (st != S_IDLE);
  assign fin      = (st == S_FIN);
  assign buf_idx  = bidx;
  assign buf_we   = (st == S_DAT) && sh_done && !kind_is_write(k_q);
  assign buf_wd   = sh_rx;

  assign after_adr = c_q.dat_en ? S_DAT : S_FIN;
  assign after_opc = kind_has_addr(k_q) ? S_ADR : after_adr;

  always_comb begin
    case (st)
      S_PFX:   sh_tx = pf_q;
      S_OPC:   sh_tx = op_q;
      S_ADR:   sh_tx = addr_byte(ad_q, bidx[1:0]);
      S_DAT:   sh_tx = kind_is_write(k_q) ? buf_rd : 8'h00;
      default: sh_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      launched <= 1'b0;
      bidx     <= '0;
      gap      <= '0;
      c_q      <= '0;
      k_q      <= K_RD;
      op_q     <= '0;
      pf_q     <= '0;
      ad_q     <= '0;
    end else begin
      if (sh_start) launched <= 1'b1;
      else if (sh_done) launched <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          c_q  <= cfg;
          k_q  <= kind;
          op_q <= opcode;
          pf_q <= prefix;
          ad_q <= addr;
          bidx <= '0;
          st   <= cfg.atomic ? S_PFX : S_OPC;
        end
        S_PFX: if (sh_done) begin
          gap <= {half, 2'b00};
          st  <= S_GAP;
        end
        S_GAP: begin
          if (gap <= 1) st <= S_OPC;
          else gap <= gap - 1'b1;
        end
        S_OPC: if (sh_done) begin
          bidx <= '0;
          st   <= after_opc;
        end
        S_ADR: if (sh_done) begin
          if (bidx == 2) begin
            bidx <= '0;
            st   <= after_adr;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
        S_DAT: if (sh_done) begin
          if (bidx == c_q.cnt) st <= S_FIN;
          else bidx <= bidx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fcyc_engine.sv
module fcyc_engine
  import fcyc_pkg::*;
#(
  parameter int DIVW      = 4,
  parameter int HALF_SLOW = 4,
  parameter int HALF_FAST = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           spi_cs_n,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso
);

  logic [7:0]      menu [MENU_N];
  logic [7:0]      mem  [BUF_BYTES];
  logic [15:0]     kinds;
  logic [7:0]      prefix_q;
  logic [23:0]     addr_q;
  ctrl_t           ctrl_q, cfg_in;
  logic            st_done, st_err, lock_q;
  logic            eng_busy, eng_fin;
  logic            go_req, go_ok, go_bad, wr_stat;
  logic            sh_start, sh_done;
  logic [7:0]      sh_tx, sh_rx;
  logic [CNTW-1:0] buf_idx;
  logic            buf_we;
  logic [7:0]      buf_wd;
  logic [DIVW-1:0] half;
  logic [CNTW-1:0] rbase;
  op_kind_t        kind_sel;

  assign cfg_in   = ctrl_decode(reg_wdata);
  assign go_req   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
  assign go_ok    = go_req && !eng_busy;
  assign go_bad   = go_req && eng_busy;
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign kind_sel = op_kind_t'(kinds[{cfg_in.idx, 1'b0} +: 2]);
  assign half     = ctrl_q.fast ? DIVW'(HALF_FAST) : DIVW'(HALF_SLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      addr_q   <= '0;
      prefix_q <= '0;
      kinds    <= '0;
      st_done  <= 1'b0;
      st_err   <= 1'b0;
      lock_q   <= 1'b0;
      for (int i = 0; i < MENU_N; i++) menu[i] <= '0;
    end else begin
      if (reg_wr && !eng_busy) begin
        if (reg_addr == A_CTRL) ctrl_q <= cfg_in;
        if (reg_addr == A_ADDR) addr_q <= reg_wdata[23:0];
      end
      if (reg_wr && !lock_q) begin
        if (reg_addr == A_PFX)  prefix_q <= reg_wdata[7:0];
        if (reg_addr == A_KIND) kinds    <= reg_wdata[15:0];
        for (int i = 0; i < MENU_N / 2; i++) begin
          if (reg_addr == A_MLO) menu[i]            <= reg_wdata[8*i +: 8];
          if (reg_addr == A_MHI) menu[i + MENU_N/2] <= reg_wdata[8*i +: 8];
        end
      end
      if (wr_stat && reg_wdata[3]) lock_q <= 1'b1;
      if (eng_fin) st_done <= 1'b1;
      else if (wr_stat && reg_wdata[1]) st_done <= 1'b0;
      if (go_bad) st_err <= 1'b1;
      else if (wr_stat && reg_wdata[2]) st_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) begin
      mem[buf_idx] <= buf_wd;
    end else if (reg_wr && reg_addr[4] && !eng_busy) begin
      for (int j = 0; j < 4; j++)
        mem[{reg_addr[3:0], 2'(j)}] <= reg_wdata[8*j +: 8];
    end
  end

  assign rbase = {reg_addr[3:0], 2'b00};

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4]) begin
      reg_rdata = {mem[rbase + 2'd3], mem[rbase + 2'd2], mem[rbase + 2'd1], mem[rbase]};
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata = ctrl_encode(ctrl_q);
        A_STAT:  reg_rdata = {28'd0, lock_q, st_err, st_done, eng_busy};
        A_ADDR:  reg_rdata = {8'd0, addr_q};
        A_PFX:   reg_rdata = {24'd0, prefix_q};
        A_KIND:  reg_rdata = {16'd0, kinds};
        A_MLO:   reg_rdata = {menu[3], menu[2], menu[1], menu[0]};
        A_MHI:   reg_rdata = {menu[7], menu[6], menu[5], menu[4]};
        default: reg_rdata = '0;
      endcase
    end
  end

  fcyc_seq #(.DIVW(DIVW)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go_ok), .cfg(cfg_in),
    .opcode(menu[cfg_in.idx]), .kind(kind_sel), .prefix(prefix_q),
    .addr(addr_q), .half(half), .sh_done(sh_done), .sh_rx(sh_rx),
    .buf_rd(mem[buf_idx]), .sh_start(sh_start), .sh_tx(sh_tx),
    .cs_n(spi_cs_n), .busy(eng_busy), .fin(eng_fin), .buf_idx(buf_idx),
    .buf_we(buf_we), .buf_wd(buf_wd)
  );

  fcyc_shifter #(.DIVW(DIVW)) shf_i (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .half(half),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done),
    .rx(sh_rx)
  );

endmodule

// File: rtl/fcyc_chk.sv
module fcyc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        lock,
  input logic        reg_wr,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata
);

  // R11
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R11
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R8
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck) && !$past(cs_n)) |-> $stable(mosi));

  // R9
  busy_go_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'd0 && reg_wdata[0] && busy) |=> err);

endmodule

bind fcyc_engine fcyc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
  .busy(eng_busy), .done(st_done), .err(st_err), .lock(lock_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/fcyc_engine_tb_top.sv
module fcyc_engine_tb_top;

  localparam int HS = 4;
  localparam int HF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fcyc_engine #(.DIVW(4), .HALF_SLOW(HS), .HALF_FAST(HF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash model ----------------
  logic [7:0] cap[$];
  int         flen[$];
  int         fl = 0;
  int         bitpos = 0;
  int         kbyte = 0;
  logic [7:0] inb = '0;
  logic [7:0] outb = '0;
  time        t_up = 0, t_rise = 0;
  int         last_gap = 0;
  int         last_half = 0;

  function automatic logic [7:0] resp(int k);
    return 8'(k * 37 + 17);
  endfunction

  always @(negedge spi_cs_n) begin
    if (rst_n) last_gap = int'(($time - t_up) / 8);
    kbyte = 0; bitpos = 0; outb = resp(0); spi_miso = outb[7];
  end

  always @(posedge spi_cs_n) begin
    if (fl > 0) flen.push_back(fl);
    fl = 0; t_up = $time;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    t_rise = $time;
    inb = {inb[6:0], spi_mosi};
    bitpos++;
    if (bitpos == 8) begin
      cap.push_back(inb); fl++; bitpos = 0;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    last_half = int'(($time - t_rise) / 8);
    if (bitpos == 0) begin kbyte++; outb = resp(kbyte); end
    else outb = {outb[6:0], 1'b0};
    spi_miso = outb[7];
  end

  // per-clock bus rule (R11)
  always @(negedge clk) if (rst_n && !finished) begin
    total++;
    if (spi_cs_n && spi_sck) begin
      bad++; $display("FAIL R11 sck=%0b exp=0 while cs_n high", spi_sck);
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(int idx, int cm1, bit de, bit at, bit fa);
    return 32'(1 | (int'(at) << 1) | (int'(de) << 2) | (int'(fa) << 3) | (idx << 4) | (cm1 << 8));
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 20000; n++) begin
      rd(5'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic clear_cap();
    cap.delete(); flen.delete();
  endtask

  task automatic check_frame(string req, int fi, logic [7:0] exp[$]);
    int base = 0;
    for (int i = 0; i < fi && i < flen.size(); i++) base += flen[i];
    chk(req, (fi < flen.size()) ? flen[fi] : -1, exp.size());
    for (int i = 0; i < exp.size(); i++)
      chk(req, (base + i < cap.size()) ? cap[base + i] : 32'hxx, exp[i]);
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'hC3;
  endfunction

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] r;
    logic [7:0]  e[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd1, r); chk("R1 status", r, 32'h0);
    chk("R1 cs_n", 32'(spi_cs_n), 32'h1);
    chk("R1 sck", 32'(spi_sck), 32'h0);

    // menu and kinds (R3 packing)
    wr(5'd5, 32'h05039F06);
    wr(5'd6, 32'hD80BC702);
    wr(5'd4, 32'h0000E721);
    wr(5'd3, 32'h00000006);
    rd(5'd5, r); chk("R10 menu writable before lock", r, 32'h05039F06);
    rd(5'd4, r); chk("R3 kinds readback", r, 32'h0000E721);

    // no-address write kind, no data (R2, R3, R8)
    clear_cap();
    wr(5'd0, mk(5, 0, 0, 0, 0));
    rd(5'd1, r); chk("R8 busy while running", r & 32'h1, 32'h1);
    wait_idle();
    rd(5'd1, r); chk("R8 done set", r, 32'h2);
    e = '{8'hC7}; check_frame("R2 opcode frame", 0, e);
    chk("R3 no address frame count", flen.size(), 1);
    wr(5'd1, 32'h2);
    rd(5'd1, r); chk("R8 done cleared by W1C", r, 32'h0);

    // read with address, 5 bytes, slow clock (R3, R5, R7)
    clear_cap();
    wr(5'd2, 32'h00123456);
    wr(5'd0, mk(2, 4, 1, 0, 0));
    wait_idle();
    e = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    check_frame("R3 R5 read frame", 0, e);
    chk("R7 slow half period", last_half, HS);
    rd(5'd16, r); chk("R5 read bytes 0-3", r, {resp(7), resp(6), resp(5), resp(4)});
    rd(5'd17, r); chk("R5 read byte 4", r & 32'hFF, 32'(resp(8)));
    wr(5'd1, 32'h2);

    // fill buffer
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});

    // prefix + write with address, 8 bytes, fast clock (R4, R6, R7)
    clear_cap();
    wr(5'd2, 32'h00ABCDEF);
    wr(5'd0, mk(4, 7, 1, 1, 1));
    wait_idle();
    e = '{8'h06}; check_frame("R6 prefix frame", 0, e);
    e = '{8'h02, 8'hAB, 8'hCD, 8'hEF};
    for (int i = 0; i < 8; i++) e.push_back(pat(i));
    check_frame("R4 write frame", 1, e);
    chk("R6 two frames", flen.size(), 2);
    chk("R6 gap at least two sck periods", 32'(last_gap >= 4 * HF), 32'h1);
    chk("R7 fast half period", last_half, HF);
    wr(5'd1, 32'h2);

    // 64-byte write with start while busy (R4 boundary, R9)
    clear_cap();
    wr(5'd2, 32'h00000100);
    wr(5'd0, mk(7, 63, 1, 0, 1));
    wr(5'd0, mk(5, 0, 0, 0, 0));
    rd(5'd1, r); chk("R9 err while busy", r, 32'h5);
    wait_idle();
    rd(5'd1, r); chk("R9 done and err after cycle", r, 32'h6);
    e = '{8'hD8, 8'h00, 8'h01, 8'h00};
    for (int i = 0; i < 64; i++) e.push_back(pat(i));
    check_frame("R4 64-byte frame", 0, e);
    chk("R9 no extra frame", flen.size(), 1);
    wr(5'd1, 32'h6);
    rd(5'd1, r); chk("R9 err cleared by W1C", r, 32'h0);

    // read without address, one byte (R3, R5)
    clear_cap();
    wr(5'd0, mk(1, 0, 1, 0, 0));
    wait_idle();
    e = '{8'h9F, 8'h00}; check_frame("R3 no-address read frame", 0, e);
    rd(5'd16, r); chk("R5 single read byte", r & 32'hFF, 32'(resp(1)));
    wr(5'd1, 32'h2);

    // lock (R10)
    wr(5'd1, 32'h8);
    rd(5'd1, r); chk("R10 lock flag", r, 32'h8);
    wr(5'd5, 32'hFFFFFFFF);
    wr(5'd6, 32'h11111111);
    wr(5'd4, 32'h0);
    wr(5'd3, 32'hAA);
    rd(5'd5, r); chk("R10 menu lo frozen", r, 32'h05039F06);
    rd(5'd6, r); chk("R10 menu hi frozen", r, 32'hD80BC702);
    rd(5'd4, r); chk("R10 kinds frozen", r, 32'h0000E721);
    rd(5'd3, r); chk("R10 prefix frozen", r, 32'h06);
    clear_cap();
    wr(5'd0, mk(0, 0, 0, 0, 0));
    wait_idle();
    e = '{8'h06}; check_frame("R10 locked opcode sent", 0, e);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule